// File: doc/BRIEF.md
# Selectable-Event Interrupt Down-Counter

This block is the interrupt timer of a cartridge bank-switching controller. An 8-bit down-counter can be driven by one of four bus events, and a two-bit mode field picks which one: a CPU bus cycle, a rising edge of the picture-processor address line A12, a picture-processor read strobe, or a CPU write strobe. The read strobe fires about 170 times per active scanline, so the read mode gives a fine, sub-scanline time base. The CPU-write mode counts the CPU's own stores.

The CPU programs the block through a small register port. It can select the event source, load the counter, enable counting, and disable counting while clearing a pending interrupt. A counted event that brings the counter to zero pulls the active-low interrupt line. The line stays low until the CPU writes the acknowledge register. The present counter value is also driven out so that the surrounding controller can use it.

Top module: `scanIrqTop`

## Requirements
- R1: After reset the counter reads 0, irqN is high, counting is disabled and the source mode is 0.
- R2: With mode 0 selected, each cycle with cpuCycle high decrements the counter by one. ppuA12 rises, ppuRead and cpuWrite have no effect.
- R3: With mode 1 selected, the counter decrements once in the cycle where the sampled ppuA12 goes from 0 to 1. A level held high for several cycles counts once. Falling edges and the other three event inputs have no effect.
- R4: With mode 2 selected, each cycle with ppuRead high decrements the counter. The other event inputs have no effect.
- R5: With mode 3 selected, each cycle with cpuWrite high decrements the counter. The other event inputs have no effect.
- R6: While counting is disabled, no event input changes the counter.
- R7: A counted event with the counter at 0 wraps it to 255 and does not assert irqN.
- R8: A counted event that takes the counter from 1 to 0 drives irqN low in the next cycle.
- R9: Once low, irqN stays low through further events and reloads. It returns high in the cycle after a write with regSel = 3 (acknowledge). That write also disables counting and suppresses any event in its own cycle.
- R10: A write with regSel = 1 loads regWrData into the counter. An enabled event in that same cycle is not counted.
- R11: A write with regSel = 0 sets the mode from regWrData[1:0] and ignores the upper bits. A write with regSel = 2 enables counting, which takes effect from the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regSel | input | 2 | Register select: 0 mode, 1 reload, 2 enable, 3 acknowledge/disable |
| regWrData | input | 8 | Register write data |
| cpuCycle | input | 1 | One-cycle pulse per CPU bus cycle |
| cpuWrite | input | 1 | One-cycle pulse per CPU write |
| ppuRead | input | 1 | One-cycle pulse per picture-processor read |
| ppuA12 | input | 1 | Sampled picture-processor address line A12 |
| irqN | output | 1 | Active-low interrupt request |
| countValue | output | 8 | Present counter value |

## Verification
The bench builds the block with its default 8-bit counter width. At that width, both the wrap from 0 to 255 and the 1-to-0 interrupt edge take only a few events to reach. A sixteen-entry table crosses every mode with every event type from the same preload, which shows that only the selected source moves the counter. Directed cases then cover a held A12 level, a reload that collides with an event, the acknowledge write, and masking of the upper bits of the mode value.

// File: rtl/scanIrqPkg.sv
package scanIrqPkg;

  typedef enum logic [1:0] {
    SRC_CPU_CYCLE = 2'd0,
    SRC_A12_RISE  = 2'd1,
    SRC_PPU_READ  = 2'd2,
    SRC_CPU_WRITE = 2'd3
  } srcMode_t;

  typedef enum logic [1:0] {
    REG_MODE   = 2'd0,
    REG_RELOAD = 2'd1,
    REG_ENABLE = 2'd2,
    REG_ACK    = 2'd3
  } regSel_t;

  typedef struct packed {
    logic load;
    logic count;
    logic ack;
  } ctrlStrobe_t;

  localparam int NUM_SRC = 4;

endpackage

// File: rtl/scanIrqCtrl.sv
module scanIrqCtrl
  import scanIrqPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWrEn,
  input  logic [1:0]  regSel,
  input  logic [1:0]  modeData,
  input  logic        cpuCycle,
  input  logic        cpuWrite,
  input  logic        ppuRead,
  input  logic        ppuA12,
  output ctrlStrobe_t strobes,
  output logic        enableQ,
  output srcMode_t    modeQ
);

  logic               a12Prev;
  logic               a12Rise;
  logic [NUM_SRC-1:0] evtVec;
  logic               selEvt;
  logic               wrReload;
  logic               wrAck;
  logic               wrEnable;
  logic               wrMode;

  assign a12Rise  = ppuA12 & ~a12Prev;
  assign wrMode   = regWrEn && (regSel == REG_MODE);
  assign wrReload = regWrEn && (regSel == REG_RELOAD);
  assign wrEnable = regWrEn && (regSel == REG_ENABLE);
  assign wrAck    = regWrEn && (regSel == REG_ACK);

  always_comb begin
    evtVec                = '0;
    evtVec[SRC_CPU_CYCLE] = cpuCycle;
    evtVec[SRC_A12_RISE]  = a12Rise;
    evtVec[SRC_PPU_READ]  = ppuRead;
    evtVec[SRC_CPU_WRITE] = cpuWrite;
  end

  assign selEvt = evtVec[modeQ];

  always_comb begin
    strobes.load  = wrReload;
    strobes.ack   = wrAck;
    strobes.count = enableQ && selEvt && !wrReload && !wrAck;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      a12Prev <= 1'b0;
      enableQ <= 1'b0;
      modeQ   <= SRC_CPU_CYCLE;
    end else begin
      a12Prev <= ppuA12;
      if (wrAck)         enableQ <= 1'b0;
      else if (wrEnable) enableQ <= 1'b1;
      if (wrMode)        modeQ   <= srcMode_t'(modeData);
    end
  end

  // R3: a held-high A12 level can produce at most one counted event
  p_a12_once_r3: assert property (@(posedge clk) disable iff (!rstN)
    (modeQ == SRC_A12_RISE) && strobes.count |=> !(ppuA12 && strobes.count));

  // R9: the acknowledge write leaves counting disabled
  p_ack_disables_r9: assert property (@(posedge clk) disable iff (!rstN)
    wrAck |=> !enableQ);

endmodule

// File: rtl/scanIrqDatapath.sv
module scanIrqDatapath
  import scanIrqPkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobe_t      strobes,
  input  logic [CNT_W-1:0] loadValue,
  output logic [CNT_W-1:0] counterQ,
  output logic             irqFlagQ
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic hitZero;
  assign hitZero = strobes.count && (counterQ == ONE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      counterQ <= '0;
      irqFlagQ <= 1'b0;
    end else begin
      if (strobes.load)       counterQ <= loadValue;
      else if (strobes.count) counterQ <= counterQ - ONE;
      if (strobes.ack)        irqFlagQ <= 1'b0;
      else if (hitZero)       irqFlagQ <= 1'b1;
    end
  end

  // R7: a counted event from zero wraps to all ones
  p_wrap_r7: assert property (@(posedge clk) disable iff (!rstN)
    strobes.count && (counterQ == '0) |=> (counterQ == '1));

  // R8: the interrupt flag rises only when the counter has reached zero
  p_irq_at_zero_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqFlagQ) |-> (counterQ == '0));

endmodule

// File: rtl/scanIrqTop.sv
module scanIrqTop
  import scanIrqPkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWrEn,
  input  logic [1:0]       regSel,
  input  logic [CNT_W-1:0] regWrData,
  input  logic             cpuCycle,
  input  logic             cpuWrite,
  input  logic             ppuRead,
  input  logic             ppuA12,
  output logic             irqN,
  output logic [CNT_W-1:0] countValue
);

  ctrlStrobe_t strobes;
  logic        enableQ;
  srcMode_t    modeQ;
  logic        irqFlagQ;

  scanIrqCtrl ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .regWrEn  (regWrEn),
    .regSel   (regSel),
    .modeData (regWrData[1:0]),
    .cpuCycle (cpuCycle),
    .cpuWrite (cpuWrite),
    .ppuRead  (ppuRead),
    .ppuA12   (ppuA12),
    .strobes  (strobes),
    .enableQ  (enableQ),
    .modeQ    (modeQ)
  );

  scanIrqDatapath #(.CNT_W(CNT_W)) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .loadValue (regWrData),
    .counterQ  (countValue),
    .irqFlagQ  (irqFlagQ)
  );

  assign irqN = ~irqFlagQ;

  // R6: a disabled counter only moves by reload
  p_idle_when_off_r6: assert property (@(posedge clk) disable iff (!rstN)
    !enableQ && !(regWrEn && regSel == REG_RELOAD) |=> $stable(countValue));

  // R9: interrupt stays low until acknowledged
  p_irq_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    !irqN && !(regWrEn && regSel == REG_ACK) |=> !irqN);

  // R9: acknowledge releases the interrupt
  p_ack_release_r9: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn && regSel == REG_ACK |=> irqN);

  // R10: reload takes the written value, regardless of events
  p_reload_r10: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn && regSel == REG_RELOAD |=> countValue == $past(regWrData));

endmodule

// File: tb/scanIrqTop_tb_top.sv
`timescale 1ns/100ps
module scanIrqTop_tb_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       regWrEn = 1'b0;
  logic [1:0] regSel = 2'd0;
  logic [7:0] regWrData = 8'd0;
  logic       cpuCycle = 1'b0;
  logic       cpuWrite = 1'b0;
  logic       ppuRead = 1'b0;
  logic       ppuA12 = 1'b0;
  logic       irqN;
  logic [7:0] countValue;

  int testCount = 0;
  int failCount = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  scanIrqTop dut_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regSel(regSel),
    .regWrData(regWrData), .cpuCycle(cpuCycle), .cpuWrite(cpuWrite),
    .ppuRead(ppuRead), .ppuA12(ppuA12), .irqN(irqN), .countValue(countValue)
  );

  // entry: {mode[11:10], eventKind[9:8], expectedCount[7:0]}, preload 10
  // eventKind: 0 cpuCycle, 1 A12 pulse, 2 ppuRead, 3 cpuWrite
  localparam logic [11:0] VEC [16] = '{
    {2'd0, 2'd0, 8'd9}, {2'd0, 2'd1, 8'd10}, {2'd0, 2'd2, 8'd10}, {2'd0, 2'd3, 8'd10},
    {2'd1, 2'd0, 8'd10}, {2'd1, 2'd1, 8'd9}, {2'd1, 2'd2, 8'd10}, {2'd1, 2'd3, 8'd10},
    {2'd2, 2'd0, 8'd10}, {2'd2, 2'd1, 8'd10}, {2'd2, 2'd2, 8'd9}, {2'd2, 2'd3, 8'd10},
    {2'd3, 2'd0, 8'd10}, {2'd3, 2'd1, 8'd10}, {2'd3, 2'd2, 8'd10}, {2'd3, 2'd3, 8'd9}
  };

  task automatic check(input string tag, input int actual, input int expected);
    testCount++;
    if (actual != expected) begin
      failCount++;
      $display("FAIL %s: actual %0d expected %0d", tag, actual, expected);
    end
  endtask

  task automatic writeReg(input logic [1:0] sel, input logic [7:0] data);
    regWrEn = 1'b1; regSel = sel; regWrData = data;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic pulse(input int kind);
    case (kind)
      0: cpuCycle = 1'b1;
      1: ppuA12 = 1'b1;
      2: ppuRead = 1'b1;
      default: cpuWrite = 1'b1;
    endcase
    @(negedge clk);
    cpuCycle = 1'b0; ppuA12 = 1'b0; ppuRead = 1'b0; cpuWrite = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 reset count", countValue, 0);
    check("R1 reset irqN", irqN, 1);
    // R1: disabled and mode 0 after reset: a cpuCycle does nothing
    pulse(0);
    check("R1 disabled after reset", countValue, 0);

    // R2 R3 R4 R5: mode x event table
    for (int i = 0; i < 16; i++) begin
      writeReg(2'd3, 8'd0);
      writeReg(2'd0, {6'd0, VEC[i][11:10]});
      writeReg(2'd1, 8'd10);
      writeReg(2'd2, 8'd0);
      pulse(int'(VEC[i][9:8]));
      case (VEC[i][11:10])
        2'd0: check("R2 mode0 source select", countValue, int'(VEC[i][7:0]));
        2'd1: check("R3 mode1 source select", countValue, int'(VEC[i][7:0]));
        2'd2: check("R4 mode2 source select", countValue, int'(VEC[i][7:0]));
        default: check("R5 mode3 source select", countValue, int'(VEC[i][7:0]));
      endcase
    end

    // R3: A12 held high for three cycles counts once
    writeReg(2'd3, 8'd0);
    writeReg(2'd0, 8'd1);
    writeReg(2'd1, 8'd10);
    writeReg(2'd2, 8'd0);
    ppuA12 = 1'b1;
    repeat (3) @(negedge clk);
    ppuA12 = 1'b0;
    @(negedge clk);
    check("R3 held level counts once", countValue, 9);

    // R6: disabled, every event ignored
    writeReg(2'd3, 8'd0);
    for (int k = 0; k < 4; k++) pulse(k);
    check("R6 disabled ignores events", countValue, 9);

    // R7: wrap from zero, no interrupt
    writeReg(2'd0, 8'd0);
    writeReg(2'd1, 8'd0);
    writeReg(2'd2, 8'd0);
    pulse(0);
    check("R7 wrap value", countValue, 255);
    check("R7 no irq on wrap", irqN, 1);

    // R8: 2 -> 1 no irq, 1 -> 0 irq
    writeReg(2'd1, 8'd2);
    pulse(0);
    check("R8 irq not yet at 1", irqN, 1);
    cpuCycle = 1'b1;
    @(negedge clk);
    cpuCycle = 1'b0;
    check("R8 irq next cycle after zero", irqN, 0);
    check("R8 count at zero", countValue, 0);

    // R9: hold through events and reloads, release on acknowledge
    pulse(0);
    writeReg(2'd1, 8'd5);
    check("R9 irq held", irqN, 0);
    regWrEn = 1'b1; regSel = 2'd3; cpuCycle = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0; cpuCycle = 1'b0;
    check("R9 irq released", irqN, 1);
    check("R9 ack cycle event suppressed", countValue, 5);
    pulse(0);
    check("R9 ack disables counting", countValue, 5);

    // R10: reload colliding with enabled event
    writeReg(2'd2, 8'd0);
    regWrEn = 1'b1; regSel = 2'd1; regWrData = 8'd40; cpuCycle = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0; cpuCycle = 1'b0;
    check("R10 reload wins over event", countValue, 40);

    // R11: upper mode bits ignored (0xFE -> mode 2)
    writeReg(2'd0, 8'hFE);
    pulse(0);
    check("R11 upper bits masked, cpuCycle ignored", countValue, 40);
    pulse(2);
    check("R11 upper bits masked, ppuRead counts", countValue, 39);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      testCount++;
      failCount++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", testCount, failCount);
      $finish;
    end
  end

endmodule